// File: doc/BRIEF.md
# Serial Frame Deframer

The deframer sits behind a bit-level receiver that has already recovered the clock and removed stuffed bits. Each cycle it may get one bit, marked by a valid strobe. It also gets an error input from the bit layer. Between frames the line carries logical zeros, and the block ignores them for as long as they last. A frame opens with three consecutive ones. A 16-bit header follows, and then a run of 16-bit payload words.

The header carries three fields. A 4-bit packet type sits in the top bits. Two spare bits come next. A 10-bit length fills the bottom, and it counts payload words. The block presents the whole header at once with a one-cycle valid pulse. It then assembles the payload one word at a time. Each finished word appears with a one-cycle valid pulse. A frame-end marker flags the last word of the frame, or the header itself when the length is zero. If the bit layer reports an error in the middle of a frame, the block raises a frame-error pulse, drops the rest of that frame and returns to searching for sync.

Top module: `frame_deframer`

## Requirements
- R1: While reset is asserted and after its release, every valid, marker and error output is low and the block is searching for sync.
- R2: Only cycles with bit_vld high carry a bit. Three consecutive accepted '1' bits start a frame. The value on bit_dat is ignored while bit_vld is low.
- R3: While searching, zeros are skipped for any length of run. One or two '1' bits followed by a '0' do not start a frame, and the count of ones restarts from that '0'.
- R4: The 16 bits after sync form the header, most significant bit first. The type is header bits 15:12 and the length is bits 9:0. hdr_vld pulses for one cycle, in the cycle after the 16th header bit is accepted.
- R5: After a nonzero length, exactly that many 16-bit words follow back to back, each most significant bit first. word_vld pulses with word_dat in the cycle after each word's 16th bit. No word is emitted while the header is being received.
- R6: frm_end is high together with word_vld for the last payload word only. A header with a nonzero length does not raise frm_end.
- R7: A length of zero ends the frame at the header. frm_end is high in the same cycle as hdr_vld, and no word follows.
- R8: If bit_err is high while a header or payload is being received, frm_err pulses in the next cycle, the bit in that cycle is dropped, no further word of that frame appears, and the search for sync restarts.
- R9: If bit_err is high while searching, frm_err stays low and any partial count of sync ones is discarded.
- R10: Once a frame ends, the very next accepted bits may begin the sync of a new frame.
- R11: The spare header bits 11:10 have no effect on framing, and they are presented unchanged on hdr_spare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Bit strobe from the bit layer |
| bit_dat | input | 1 | Destuffed data bit |
| bit_err | input | 1 | Error indication from the bit layer |
| hdr_vld | output | 1 | One-cycle pulse when a header is complete |
| hdr_type | output | 4 | Packet type field |
| hdr_spare | output | 2 | Spare header bits, passed through |
| hdr_len | output | 10 | Payload length in words |
| word_vld | output | 1 | One-cycle pulse when a payload word is complete |
| word_dat | output | 16 | Payload word |
| frm_end | output | 1 | Marks the last word, or a header with zero length |
| frm_err | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
All results are registered, one stage after the accepted bit that completes them. hdr_vld and the header fields are due in the cycle after the 16th header bit. Each word_vld and its frm_end are due in the cycle after that word's 16th bit. frm_err is due in the cycle after bit_err. The bench changes inputs on the falling edge and reads outputs at the next falling edge, so every check lands exactly in the cycle where its result is due. Event counters sampled shortly after each rising edge confirm that no extra header, word or error pulse appears in between.

// File: rtl/deframer_pkg.sv
package deframer_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } dfr_state_e;
endpackage

// File: rtl/deframer_sync.sv
// Counts consecutive accepted ones while the block searches for sync.
module deframer_sync #(
  parameter int SYNC_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic hit
);
  localparam int CW = $clog2(SYNC_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = en && din && (cnt_q == CW'(SYNC_LEN - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      if (!din || hit) cnt_d = '0;
      else             cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_SYNC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(SYNC_LEN)); // R2
  AST_ZERO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !din) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/deframer_shift.sv
// Collects bits MSB first and flags the bit that completes a word.
module deframer_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [WORD_W-1:0] word_nxt,
  output logic              done
);
  localparam int CW = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  assign word_nxt = {sh_q[WORD_W-2:0], din};
  assign done     = en && (cnt_q == CW'(WORD_W - 1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      sh_d  = word_nxt;
      cnt_d = done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/deframer_ctrl.sv
// Frame state machine: header capture, word counting, end and error pulses.
module deframer_ctrl
  import deframer_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int TYPE_W = 4,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_err,
  input  logic              sync_hit,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_nxt,
  output logic              hunting,
  output logic              hdr_vld,
  output logic [TYPE_W-1:0] hdr_type,
  output logic [WORD_W-TYPE_W-LEN_W-1:0] hdr_spare,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_dat,
  output logic              frm_end,
  output logic              frm_err
);
  localparam int SP_W = WORD_W - TYPE_W - LEN_W;

  dfr_state_e        state_q, state_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              hdr_vld_d, word_vld_d, frm_end_d, frm_err_d;
  logic [TYPE_W-1:0] type_d;
  logic [SP_W-1:0]   spare_d;
  logic [LEN_W-1:0]  len_d, len_f;
  logic [WORD_W-1:0] dat_d;

  assign hunting = (state_q == ST_HUNT);
  assign len_f   = word_nxt[LEN_W-1:0];

  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    hdr_vld_d  = 1'b0;
    word_vld_d = 1'b0;
    frm_end_d  = 1'b0;
    frm_err_d  = 1'b0;
    type_d     = hdr_type;
    spare_d    = hdr_spare;
    len_d      = hdr_len;
    dat_d      = word_dat;
    if (!hunting && bit_err) begin
      frm_err_d = 1'b1;
      state_d   = ST_HUNT;
    end else begin
      unique case (state_q)
        ST_HUNT: if (sync_hit) state_d = ST_HDR;
        ST_HDR: if (word_done) begin
          hdr_vld_d = 1'b1;
          type_d    = word_nxt[WORD_W-1 -: TYPE_W];
          spare_d   = word_nxt[LEN_W +: SP_W];
          len_d     = len_f;
          rem_d     = len_f;
          if (len_f == '0) begin
            frm_end_d = 1'b1;
            state_d   = ST_HUNT;
          end else begin
            state_d = ST_PAY;
          end
        end
        ST_PAY: if (word_done) begin
          word_vld_d = 1'b1;
          dat_d      = word_nxt;
          rem_d      = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin
            frm_end_d = 1'b1;
            state_d   = ST_HUNT;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT;
      rem_q     <= '0;
      hdr_vld   <= 1'b0;
      word_vld  <= 1'b0;
      frm_end   <= 1'b0;
      frm_err   <= 1'b0;
      hdr_type  <= '0;
      hdr_spare <= '0;
      hdr_len   <= '0;
      word_dat  <= '0;
    end else begin
      state_q   <= state_d;
      rem_q     <= rem_d;
      hdr_vld   <= hdr_vld_d;
      word_vld  <= word_vld_d;
      frm_end   <= frm_end_d;
      frm_err   <= frm_err_d;
      hdr_type  <= type_d;
      hdr_spare <= spare_d;
      hdr_len   <= len_d;
      word_dat  <= dat_d;
    end
  end

  AST_PAY_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAY) |-> (rem_q != '0)); // R5
  AST_END_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> (word_vld || hdr_vld)); // R6
  AST_LONG_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_vld && hdr_len != '0) |-> !frm_end); // R6
  AST_ZERO_LEN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_vld && hdr_len == '0) |-> frm_end); // R7
  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> !(word_vld || hdr_vld || frm_end)); // R8
  AST_ERR_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> hunting); // R8
  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && bit_err) |=> !frm_err); // R9
endmodule

// File: rtl/frame_deframer.sv
module frame_deframer #(
  parameter int WORD_W   = 16,
  parameter int TYPE_W   = 4,
  parameter int LEN_W    = 10,
  parameter int SYNC_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_dat,
  input  logic              bit_err,
  output logic              hdr_vld,
  output logic [TYPE_W-1:0] hdr_type,
  output logic [WORD_W-TYPE_W-LEN_W-1:0] hdr_spare,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_dat,
  output logic              frm_end,
  output logic              frm_err
);
  logic              hunting, sync_hit, word_done;
  logic              sync_en, sync_clr, sh_en, sh_clr;
  logic [WORD_W-1:0] word_nxt;

  assign sync_en  = bit_vld && hunting && !bit_err;
  assign sync_clr = !hunting || bit_err;
  assign sh_en    = bit_vld && !hunting && !bit_err;
  assign sh_clr   = hunting || bit_err;

  deframer_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr), .en(sync_en),
    .din(bit_dat), .hit(sync_hit)
  );

  deframer_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .en(sh_en),
    .din(bit_dat), .word_nxt(word_nxt), .done(word_done)
  );

  deframer_ctrl #(.WORD_W(WORD_W), .TYPE_W(TYPE_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_err(bit_err), .sync_hit(sync_hit),
    .word_done(word_done), .word_nxt(word_nxt), .hunting(hunting),
    .hdr_vld(hdr_vld), .hdr_type(hdr_type), .hdr_spare(hdr_spare),
    .hdr_len(hdr_len), .word_vld(word_vld), .word_dat(word_dat),
    .frm_end(frm_end), .frm_err(frm_err)
  );

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_vld, word_vld, frm_err})); // R5
endmodule

// File: tb/frame_deframer_bench.sv
`timescale 1ns/1ps
module frame_deframer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_vld, bit_dat, bit_err;
  logic        hdr_vld, word_vld, frm_end, frm_err;
  logic [3:0]  hdr_type;
  logic [1:0]  hdr_spare;
  logic [9:0]  hdr_len;
  logic [15:0] word_dat;

  int n_chk = 0, n_bad = 0;
  int n_hdr = 0, n_word = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_deframer u_frame_deframer (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .bit_err(bit_err), .hdr_vld(hdr_vld), .hdr_type(hdr_type),
    .hdr_spare(hdr_spare), .hdr_len(hdr_len), .word_vld(word_vld),
    .word_dat(word_dat), .frm_end(frm_end), .frm_err(frm_err)
  );

  always @(posedge clk) begin
    #1;
    if (hdr_vld)  n_hdr++;
    if (word_vld) n_word++;
    if (frm_err)  n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_vld = 1'b1; bit_dat = b;
    @(negedge clk);
    bit_vld = 1'b0; bit_dat = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin bit_dat = 1'b1; @(negedge clk); end
    bit_dat = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input bit gappy);
    for (int i = 15; i >= 0; i--) begin
      if (gappy && (i % 5 == 0)) idle(2);
      send_bit(w[i]);
    end
  endtask

  function automatic logic [15:0] pay(input logic [15:0] base, input int i);
    return base ^ 16'(i * 16'h0303);
  endfunction

  task automatic run_frame(input logic [3:0] ty, input logic [1:0] sp,
                           input logic [9:0] len, input logic [15:0] base,
                           input bit gappy, input int zeros);
    int w0, h0;
    repeat (zeros) send_bit(1'b0);
    repeat (3) send_bit(1'b1);
    w0 = n_word; h0 = n_hdr;
    send_word({ty, sp, len}, gappy);
    chk(hdr_vld == 1'b1, "R4 hdr_vld", hdr_vld, 1);
    chk(hdr_type == ty, "R4 type", hdr_type, ty);
    chk(hdr_len == len, "R4 len", hdr_len, len);
    chk(hdr_spare == sp, "R11 spare", hdr_spare, sp);
    chk(frm_end == (len == 0), "R7 end at header", frm_end, len == 0);
    chk(n_word == w0, "R5 no word during header", n_word - w0, 0);
    for (int i = 0; i < int'(len); i++) begin
      send_word(pay(base, i), gappy);
      chk(word_vld == 1'b1, "R5 word_vld", word_vld, 1);
      chk(word_dat == pay(base, i), "R5 word_dat", word_dat, pay(base, i));
      chk(frm_end == (i == int'(len) - 1), "R6 end marker", frm_end, i == int'(len) - 1);
    end
    chk(n_hdr == h0 + 1, "R4 single header", n_hdr - h0, 1);
    chk(n_word == w0 + int'(len), "R5 word count", n_word - w0, len);
  endtask

  task automatic t_reset();
    chk(!hdr_vld && !word_vld && !frm_end && !frm_err, "R1 reset outputs",
        {hdr_vld, word_vld, frm_end, frm_err}, 0);
  endtask

  task automatic t_basic();
    run_frame(4'hA, 2'b01, 10'd3, 16'hC35A, 1'b1, 9); // R2 gaps with bit_dat=1
  endtask

  task automatic t_partial_sync();
    int h0;
    h0 = n_hdr;
    send_bit(1); send_bit(0); send_bit(0);
    send_bit(1); send_bit(1); send_bit(0);
    chk(n_hdr == h0, "R3 no false start", n_hdr - h0, 0);
    run_frame(4'h5, 2'b10, 10'd2, 16'h0F0F, 1'b0, 0); // R3 restart count
  endtask

  task automatic t_zero_len();
    run_frame(4'h3, 2'b11, 10'd0, 16'h0, 1'b0, 2); // R7
    run_frame(4'hF, 2'b00, 10'd1, 16'hBEEF, 1'b0, 0); // R10 back to back
  endtask

  task automatic t_err_payload();
    int w0, e0;
    repeat (3) send_bit(1'b1);
    send_word({4'h7, 2'b00, 10'd4}, 1'b0);
    send_word(16'h1234, 1'b0);
    repeat (5) send_bit(1'b1);
    w0 = n_word; e0 = n_err;
    bit_err = 1'b1; bit_vld = 1'b1; bit_dat = 1'b1;
    @(negedge clk);
    bit_err = 1'b0; bit_vld = 1'b0; bit_dat = 1'b0;
    chk(frm_err == 1'b1, "R8 frm_err pulse", frm_err, 1);
    repeat (11) send_bit(1'b0);
    chk(n_word == w0, "R8 no word after error", n_word - w0, 0);
    chk(n_err == e0 + 1, "R8 single error", n_err - e0, 1);
    run_frame(4'h2, 2'b01, 10'd1, 16'h5555, 1'b0, 1); // R8 hunt resumed
  endtask

  task automatic t_err_hunt();
    int h0, e0;
    h0 = n_hdr; e0 = n_err;
    send_bit(1); send_bit(1);
    bit_err = 1'b1; @(negedge clk); bit_err = 1'b0;
    chk(frm_err == 1'b0, "R9 no frm_err in hunt", frm_err, 0);
    send_bit(1);
    send_word(16'h0000, 1'b0);
    chk(n_hdr == h0, "R9 partial sync dropped", n_hdr - h0, 0);
    chk(n_err == e0, "R9 no error count", n_err - e0, 0);
  endtask

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_dat = 1'b0; bit_err = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial_sync();
    t_zero_len();
    t_err_payload();
    t_err_hunt();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule